// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power State Controller

This block sits beside the command scheduler of an SDRAM controller. It keeps track of how many AUTO REFRESH commands the memory is owed. A free-running interval timer adds one owed refresh each time the average refresh period passes. The block asks the scheduler for a command slot whenever a refresh is owed and every bank reports idle. Address bits do not matter for a refresh, so the handshake carries no row or bank. Once the scheduler grants the slot, the block holds off all other commands until the refresh cycle time has passed.

The block also drives the clock-enable level. It enters power-down on request and records whether the entry was with all banks precharged or with a row still open. It enters self refresh only when all banks are idle. On leaving self refresh it applies two recovery windows. A short one holds off every command. A much longer one, sized for the delay-locked loop to relock, withholds permission to read. Owed refreshes may be postponed while banks are busy, up to a fixed budget. Once a second refresh has come due before the first was served, an urgency flag rises, and that flag also forces a wake from power-down.

Top module: `sdr_refpwr_ctrl`

## Requirements
- R1: After reset, cke is 1, cmd_block is 0, ref_req is 0, ref_urgent is 0, read_ok is 1 and pd_active is 0.
- R2: With the default parameters the interval is 1560 cycles. One refresh becomes owed on the 1560th clock edge after reset, or after the self-refresh exit edge. ref_req is high only in normal operation, while at least one refresh is owed and banks_idle is 1.
- R3: A refresh is issued on a clock edge where ref_req and ref_gnt are both 1. From the next cycle, cmd_block is high for exactly 5 cycles (47 ns at 100 MHz, rounded up) and ref_req stays low during those cycles.
- R4: An owed refresh is kept while banks_idle is 0. ref_urgent is 1 while two or more refreshes are owed, and it falls once a grant brings the count below two.
- R5: The count of owed refreshes saturates at 8. After a long busy period, exactly 8 grants are accepted before ref_req falls.
- R6: In normal operation, with sr_req low, ref_urgent low and no refresh granted, pd_req drives cke low on the next edge. pd_active becomes the inverse of banks_idle at that edge: 1 means active power-down, 0 means precharge power-down.
- R7: When pd_req falls during power-down, cke returns to 1 on the next edge and cmd_block stays high for that one cycle only.
- R8: If ref_urgent rises during power-down, cke returns to 1 on the next edge even though pd_req is still high. Power-down is not entered again while ref_urgent is 1.
- R9: Self refresh is entered (cke low) only when sr_req is high and banks_idle is 1. While sr_req is high, pd_req is ignored, so sr_req with busy banks leaves cke at 1.
- R10: When sr_req falls during self refresh, cke returns to 1 on the next edge. cmd_block stays high for 5 cycles. read_ok stays low until 200 cycles after the first cycle with cke high.
- R11: While in self refresh, read_ok is 0 and ref_req is 0. The count of owed refreshes is cleared, so no refresh is owed right after exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| banks_idle | input | 1 | All banks precharged |
| sr_req | input | 1 | Level request to stay in self refresh |
| pd_req | input | 1 | Level request to stay in power-down |
| ref_gnt | input | 1 | Scheduler gives the command slot to a refresh |
| ref_req | output | 1 | A refresh is owed and may be issued now |
| ref_urgent | output | 1 | Two or more refreshes owed |
| cke | output | 1 | Clock-enable level for the memory |
| cmd_block | output | 1 | Hold off all other commands |
| read_ok | output | 1 | READ commands permitted (relock window over) |
| pd_active | output | 1 | Power-down was entered with a row open |

## Verification
The hardest state to reach is a saturated refresh budget, together with an urgency-forced wake from power-down. Both need thousands of cycles in which refreshes come due but cannot be served. The bench holds banks_idle low, or keeps pd_req high, across several whole intervals from a fresh reset, so the timer phase is known. It then serves the backlog inside a single interval and counts the grants. The self-refresh test keeps the block asleep for longer than one interval, so that clearing of the owed count can be seen at ref_req after exit.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [2:0] {
        ST_RUN,   // normal operation
        ST_RFC,   // refresh recovery
        ST_PD,    // power-down, cke low
        ST_PDX,   // one-cycle wake from power-down
        ST_SR,    // self refresh, cke low
        ST_XSR    // self-refresh exit recovery
    } pstate_e;
endpackage

// File: rtl/rpc_interval_timer.sv
module rpc_interval_timer #(
    parameter int INT_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int TW = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (clear) begin
            d.cnt = '0;
        end else if (q.cnt == TW'(INT_CYC - 1)) begin
            tick  = 1'b1;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rpc_refresh_debt.sv
module rpc_refresh_debt #(
    parameter int MAX_OWED    = 8,
    parameter int URGENT_OWED = 2,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic          issue,
    output logic [OW-1:0] owed,
    output logic          urgent
);
    typedef struct packed {
        logic [OW-1:0] owed;
    } debt_t;

    debt_t q, d;
    logic [OW:0] sum;

    always_comb begin
        d   = q;
        sum = {1'b0, q.owed} + {{OW{1'b0}}, tick} - {{OW{1'b0}}, issue};
        if (clear)                         d.owed = '0;
        else if (sum > (OW+1)'(MAX_OWED))  d.owed = OW'(MAX_OWED);
        else                               d.owed = sum[OW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign owed   = q.owed;
    assign urgent = (q.owed >= OW'(URGENT_OWED));
endmodule

// File: rtl/rpc_window.sv
module rpc_window #(
    parameter int CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int WW = $clog2(CYC + 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
    } win_t;

    win_t q, d;

    always_comb begin
        d = q;
        if (load)              d.cnt = WW'(CYC);
        else if (q.cnt != '0)  d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = (q.cnt == '0);
endmodule

// File: rtl/sdr_refpwr_ctrl.sv
module sdr_refpwr_ctrl
    import rpc_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int REFI_NS     = 15600,
    parameter int TRFC_NS     = 47,
    parameter int TXSNR_NS    = 47,
    parameter int TXSRD_CYC   = 200,
    parameter int MAX_OWED    = 8,
    parameter int URGENT_OWED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_idle,
    input  logic sr_req,
    input  logic pd_req,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic cke,
    output logic cmd_block,
    output logic read_ok,
    output logic pd_active
);
    localparam int INT_CYC   = (CLK_MHZ * REFI_NS) / 1000;
    localparam int TRFC_CYC  = (TRFC_NS * CLK_MHZ + 999) / 1000;
    localparam int TXSNR_CYC = (TXSNR_NS * CLK_MHZ + 999) / 1000;
    localparam int REC_MAX   = (TRFC_CYC > TXSNR_CYC) ? TRFC_CYC : TXSNR_CYC;
    localparam int RW        = $clog2(REC_MAX + 1);
    localparam int OW        = $clog2(MAX_OWED + 1);

    typedef struct packed {
        pstate_e       state;
        logic [RW-1:0] rec;
        logic          cke;
        logic          pd_active;
    } fsm_t;

    fsm_t q, d;

    logic          tick;
    logic          issue;
    logic          in_sr;
    logic          relock_done;
    logic [OW-1:0] owed;
    logic          urgent;

    assign in_sr = (q.state == ST_SR);

    rpc_interval_timer #(.INT_CYC(INT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (in_sr),
        .tick  (tick)
    );

    rpc_refresh_debt #(.MAX_OWED(MAX_OWED), .URGENT_OWED(URGENT_OWED)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (in_sr),
        .tick   (tick),
        .issue  (issue),
        .owed   (owed),
        .urgent (urgent)
    );

    rpc_window #(.CYC(TXSRD_CYC)) u_relock (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_sr),
        .done  (relock_done)
    );

    assign ref_req = (q.state == ST_RUN) && (owed != '0) && banks_idle;
    assign issue   = ref_req && ref_gnt;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_RUN: begin
                if (issue) begin
                    d.state = ST_RFC;
                    d.rec   = RW'(TRFC_CYC - 1);
                end else if (sr_req) begin
                    if (banks_idle) begin
                        d.state = ST_SR;
                        d.cke   = 1'b0;
                    end
                end else if (pd_req && !urgent) begin
                    d.state     = ST_PD;
                    d.cke       = 1'b0;
                    d.pd_active = !banks_idle;
                end
            end
            ST_RFC, ST_XSR: begin
                if (q.rec == '0) d.state = ST_RUN;
                else             d.rec   = q.rec - 1'b1;
            end
            ST_PD: begin
                if (!pd_req || sr_req || urgent) begin
                    d.state     = ST_PDX;
                    d.cke       = 1'b1;
                    d.pd_active = 1'b0;
                end
            end
            ST_PDX: begin
                d.state = ST_RUN;
            end
            ST_SR: begin
                if (!sr_req) begin
                    d.state = ST_XSR;
                    d.cke   = 1'b1;
                    d.rec   = RW'(TXSNR_CYC - 1);
                end
            end
            default: begin
                d.state = ST_RUN;
                d.cke   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_RUN;
            q.rec       <= '0;
            q.cke       <= 1'b1;
            q.pd_active <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cke        = q.cke;
    assign cmd_block  = (q.state != ST_RUN);
    assign read_ok    = relock_done && !in_sr;
    assign pd_active  = q.pd_active;
    assign ref_urgent = urgent;
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker (
    input logic clk,
    input logic rst_n,
    input logic banks_idle,
    input logic ref_gnt,
    input logic ref_req,
    input logic cmd_block,
    input logic cke,
    input logic read_ok
);
    AST_REQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> banks_idle);  // R2

    AST_ISSUE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (cmd_block && !ref_req));  // R3

    AST_LOWPWR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd_block && !ref_req));  // R6

    AST_WAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cmd_block);  // R7

    AST_READ_DROP_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_ok) |-> !cke);  // R11
endmodule

bind sdr_refpwr_ctrl rpc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .cmd_block  (cmd_block),
    .cke        (cke),
    .read_ok    (read_ok)
);

// File: tb/sdr_refpwr_ctrl_tb.sv
module sdr_refpwr_ctrl_tb;
    localparam int INT = 100 * 15600 / 1000;   // 1560 cycles
    localparam int REC = 5;
    localparam int RELOCK = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b1;
    logic sr_req = 1'b0;
    logic pd_req = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_urgent, cke, cmd_block, read_ok, pd_active;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sdr_refpwr_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .banks_idle (banks_idle),
        .sr_req     (sr_req),
        .pd_req     (pd_req),
        .ref_gnt    (ref_gnt),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .cke        (cke),
        .cmd_block  (cmd_block),
        .read_ok    (read_ok),
        .pd_active  (pd_active)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        banks_idle = 1'b1; sr_req = 1'b0; pd_req = 1'b0; ref_gnt = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "cke", cke, 1);
        chk("R1", "cmd_block", cmd_block, 0);
        chk("R1", "ref_req", ref_req, 0);
        chk("R1", "ref_urgent", ref_urgent, 0);
        chk("R1", "read_ok", read_ok, 1);
        chk("R1", "pd_active", pd_active, 0);
    endtask

    task automatic t_interval_and_issue();
        do_reset();
        step(INT - 1);
        chk("R2", "ref_req before interval", ref_req, 0);
        step(1);
        chk("R2", "ref_req at interval", ref_req, 1);
        ref_gnt = 1'b1;
        step(1);
        ref_gnt = 1'b0;
        chk("R3", "cmd_block after grant", cmd_block, 1);
        chk("R3", "ref_req after grant", ref_req, 0);
        for (int i = 2; i <= REC; i++) begin
            step(1);
            chk("R3", "cmd_block in recovery", cmd_block, 1);
        end
        step(1);
        chk("R3", "cmd_block after recovery", cmd_block, 0);
    endtask

    task automatic t_busy_postpone();
        do_reset();
        banks_idle = 1'b0;
        step(INT);
        chk("R4", "ref_req while busy", ref_req, 0);
        chk("R4", "urgent with one owed", ref_urgent, 0);
        step(INT);
        chk("R4", "urgent with two owed", ref_urgent, 1);
        banks_idle = 1'b1;
        step(1);
        chk("R4", "ref_req once idle", ref_req, 1);
        ref_gnt = 1'b1;
        step(1);
        ref_gnt = 1'b0;
        chk("R4", "urgent after one grant", ref_urgent, 0);
        step(REC);
        chk("R4", "second owed still requested", ref_req, 1);
    endtask

    task automatic t_budget();
        int grants = 0;
        do_reset();
        banks_idle = 1'b0;
        step(9 * INT + 10);
        chk("R5", "urgent after long busy", ref_urgent, 1);
        banks_idle = 1'b1;
        for (int g = 0; g < 12; g++) begin
            if (ref_req) begin
                ref_gnt = 1'b1;
                step(1);
                ref_gnt = 1'b0;
                grants++;
                step(REC);
            end else begin
                step(1);
            end
        end
        chk("R5", "grants accepted", grants, 8);
    endtask

    task automatic t_power_down();
        do_reset();
        pd_req = 1'b1;
        step(1);
        chk("R6", "cke on entry", cke, 0);
        chk("R6", "precharge power-down kind", pd_active, 0);
        step(3);
        chk("R6", "cke held low", cke, 0);
        pd_req = 1'b0;
        step(1);
        chk("R7", "cke on exit", cke, 1);
        chk("R7", "block in wake cycle", cmd_block, 1);
        step(1);
        chk("R7", "block after wake cycle", cmd_block, 0);
        banks_idle = 1'b0;
        pd_req = 1'b1;
        step(1);
        chk("R6", "cke active entry", cke, 0);
        chk("R6", "active power-down kind", pd_active, 1);
        pd_req = 1'b0;
        banks_idle = 1'b1;
        step(2);
        chk("R7", "cke back high", cke, 1);
    endtask

    task automatic t_pd_urgent_wake();
        do_reset();
        pd_req = 1'b1;
        step(1);
        chk("R8", "cke entered", cke, 0);
        step(2 * INT - 1);
        chk("R8", "still asleep as urgency rises", cke, 0);
        chk("R8", "urgent raised", ref_urgent, 1);
        step(1);
        chk("R8", "forced wake", cke, 1);
        step(1);
        chk("R8", "no re-entry while urgent", cke, 1);
        chk("R8", "refresh requested", ref_req, 1);
        ref_gnt = 1'b1;
        step(1);
        ref_gnt = 1'b0;
        step(REC + 1);
        chk("R8", "re-entry once not urgent", cke, 0);
        pd_req = 1'b0;
        step(2);
    endtask

    task automatic t_self_refresh();
        do_reset();
        banks_idle = 1'b0;
        sr_req = 1'b1;
        pd_req = 1'b1;
        step(3);
        chk("R9", "no sleep while busy", cke, 1);
        banks_idle = 1'b1;
        step(1);
        chk("R9", "self refresh entered", cke, 0);
        step(2);
        chk("R9", "self refresh chosen over power-down", read_ok, 0);
        step(INT + 5);
        chk("R11", "ref_req in self refresh", ref_req, 0);
        chk("R11", "read_ok in self refresh", read_ok, 0);
        pd_req = 1'b0;
        sr_req = 1'b0;
        step(1);
        chk("R10", "cke on exit", cke, 1);
        chk("R10", "block on exit", cmd_block, 1);
        for (int j = 2; j <= REC; j++) begin
            step(1);
            chk("R10", "block in exit window", cmd_block, 1);
        end
        step(1);
        chk("R10", "block after exit window", cmd_block, 0);
        chk("R10", "read still withheld", read_ok, 0);
        step(RELOCK - 1 - REC);
        chk("R10", "read withheld at 199", read_ok, 0);
        step(1);
        chk("R10", "read permitted at 200", read_ok, 1);
        chk("R11", "no owed refresh after exit", ref_req, 0);
        step(INT - (RELOCK + 1));
        chk("R2", "no request one before interval", ref_req, 0);
        step(1);
        chk("R2", "request one interval after exit", ref_req, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_interval_and_issue();
        t_busy_postpone();
        t_budget();
        t_power_down();
        t_pd_urgent_wake();
        t_self_refresh();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule